// File: doc/BRIEF.md
# Quadlet-Serial CRC-16 Engine

This block computes the 16-bit check value that guards serial-bus configuration and map structures. The data is a block of 32-bit quadlets. A one-cycle `start` pulse opens a block and clears the accumulator. Each quadlet is then taken on a valid/ready handshake, and the quadlet flagged with `in_last` closes the block. In the cycle the result is ready, `done` pulses high for one cycle. At that point `crc_out` holds the check value, and `hdr_out` holds a ready-made map header: the quadlet count in the upper half and the CRC in the lower half.

The update works on one 4-bit nibble at a time, with feedback taps at bit offsets 12, 5 and 0. Each quadlet is fed as eight nibbles, most significant first. The `ITERATIVE` parameter sets how each quadlet is processed:
- `ITERATIVE = 0`: all eight nibble steps are unrolled into one combinational stage, so a quadlet can be taken every cycle.
- `ITERATIVE = 1`: one nibble step is reused over eight cycles, and `in_ready` stays low while that runs.

Both variants give the same results.

Top module: `crcq_engine`

## Requirements
- R1: After reset, `done` is 0, `crc_out` is 0, `hdr_out` is 0 and `in_ready` is 1.
- R2: Each quadlet is consumed as eight nibbles, bits 31:28 first and bits 3:0 last. For each nibble n, with s = crc[15:12] XOR n, the update is crc = ((crc << 4) XOR (s << 12) XOR (s << 5) XOR s), truncated to 16 bits.
- R3: The accumulator starts at 0 for every block. The result covers exactly the quadlets accepted (in_valid and in_ready both high at a rising edge) from the first one after `start` up to and including the one with `in_last` = 1.
- R4: At `done`, `hdr_out[31:16]` is the number of quadlets in the block and `hdr_out[15:0]` equals `crc_out`.
- R5: `done` is high for exactly one cycle per block. With `ITERATIVE` = 0 it is high in the cycle right after the edge that accepts the last quadlet. With `ITERATIVE` = 1 it rises eight clock edges later than that.
- R6: With `ITERATIVE` = 1, `in_ready` is low for exactly 8 cycles after each accepted quadlet. With `ITERATIVE` = 0 it does not drop after an accept.
- R7: A `start` pulse in the middle of a block discards the quadlets already taken. The next result depends only on the quadlets accepted after that pulse.
- R8: `crc_out` and `hdr_out` keep their values until the next `done` or `start`. A `start` sets both to 0 and keeps `done` low in the following cycle.
- R9: `in_ready` is low in any cycle where `start` is high, so a quadlet offered in that cycle is not consumed.
- R10: After the last quadlet, the accumulator and the count return to zero by themselves. A second block that follows without a `start` pulse gives its own independent result.
- R11: Cycles with `in_valid` low between quadlets have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that opens a new block and clears all state |
| in_valid | input | 1 | A quadlet is offered on `in_data` |
| in_ready | output | 1 | The engine will take the offered quadlet at this edge |
| in_data | input | 32 | Quadlet data |
| in_last | input | 1 | Marks the offered quadlet as the final one of the block |
| done | output | 1 | One-cycle strobe: the result registers have just been loaded |
| crc_out | output | 16 | Check value of the most recent block |
| hdr_out | output | 32 | Quadlet count (bits 31:16) and check value (bits 15:0) |

## Verification
The bench runs both variants on pseudo-random blocks of 1 to 64 quadlets and compares each result with an independent nibble model. A design that reversed the nibble order, took a tap at the wrong offset, or skipped a step would give a different value in almost every block.

The bench also targets the boundary cases:
- An abort in mid-block. A design that failed to clear the accumulator here would carry stale state into the next result.
- A quadlet offered in the same cycle as `start`. A design that took it would add a spurious quadlet.
- Back-to-back blocks with no `start` between them. A design that did not self-clear after `in_last` would chain the two blocks together.
- Idle gaps between quadlets, which a design must not count.
- The exact cycle of `done` and the width of the `in_ready` gap. A design that was off by one in the iterative step counter would show up here as a wrong latency.

// File: rtl/crcq_pkg.sv
package crcq_pkg;
  localparam int CRC_W = 16;
  localparam int NIB_W = 4;

  typedef logic [CRC_W-1:0] crc_t;
  typedef logic [NIB_W-1:0] nib_t;

  // One nibble of the feedback update, taps at offsets 12, 5 and 0
  function automatic crc_t nib_update(crc_t cur, nib_t nib);
    nib_t s;
    crc_t r;
    s = cur[CRC_W-1 -: NIB_W] ^ nib;
    r = {cur[CRC_W-NIB_W-1:0], {NIB_W{1'b0}}};
    r = r ^ {s, 12'b0} ^ {7'b0, s, 5'b0} ^ {12'b0, s};
    return r;
  endfunction
endpackage

// File: rtl/crcq_step.sv
module crcq_step
  import crcq_pkg::*;
(
  input  crc_t crc_i,
  input  nib_t nib_i,
  output crc_t crc_o
);
  assign crc_o = nib_update(crc_i, nib_i);
endmodule

// File: rtl/crcq_chain.sv
module crcq_chain
  import crcq_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  crc_t                     seed_i,
  input  logic [STEPS*NIB_W-1:0]   data_i,
  output crc_t                     crc_o
);
  crc_t stage [0:STEPS];

  assign stage[0] = seed_i;

  // Most significant nibble enters first
  for (genvar g = 0; g < STEPS; g++) begin : g_stage
    crcq_step u_step (
      .crc_i (stage[g]),
      .nib_i (data_i[(STEPS-1-g)*NIB_W +: NIB_W]),
      .crc_o (stage[g+1])
    );
  end

  assign crc_o = stage[STEPS];
endmodule

// File: rtl/crcq_core.sv
module crcq_core
  import crcq_pkg::*;
#(
  parameter int ITERATIVE = 0,
  parameter int WORD_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic              take_last,
  input  logic [WORD_W-1:0] word_i,
  output logic              busy_o,
  output logic              fin_o,
  output crc_t              fin_crc_o
);
  localparam int NIBS = WORD_W / NIB_W;
  localparam int SW   = (NIBS > 1) ? $clog2(NIBS) : 1;

  if (ITERATIVE == 0) begin : g_unroll
    crc_t acc;
    crc_t nxt;

    crcq_chain #(.STEPS(NIBS)) u_chain (
      .seed_i (acc),
      .data_i (word_i),
      .crc_o  (nxt)
    );

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        acc <= '0;
      end else if (take) begin
        acc <= take_last ? '0 : nxt;
      end
    end

    assign busy_o    = 1'b0;
    assign fin_o     = take & take_last & ~clear;
    assign fin_crc_o = nxt;
  end else begin : g_iter
    localparam logic [SW-1:0] LAST_STEP = SW'(NIBS - 1);

    crc_t              acc;
    crc_t              nxt;
    logic [WORD_W-1:0] sh;
    logic [SW-1:0]     step;
    logic              busy;
    logic              lastq;

    crcq_chain #(.STEPS(1)) u_chain (
      .seed_i (acc),
      .data_i (sh[WORD_W-1 -: NIB_W]),
      .crc_o  (nxt)
    );

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        acc   <= '0;
        sh    <= '0;
        step  <= '0;
        busy  <= 1'b0;
        lastq <= 1'b0;
      end else if (take) begin
        sh    <= word_i;
        step  <= '0;
        busy  <= 1'b1;
        lastq <= take_last;
      end else if (busy) begin
        sh   <= {sh[WORD_W-NIB_W-1:0], {NIB_W{1'b0}}};
        step <= step + 1'b1;
        if (step == LAST_STEP) begin
          busy <= 1'b0;
          acc  <= lastq ? '0 : nxt;
        end else begin
          acc  <= nxt;
        end
      end
    end

    assign busy_o    = busy;
    assign fin_o     = busy & (step == LAST_STEP) & lastq & ~clear;
    assign fin_crc_o = nxt;
  end
endmodule

// File: rtl/crcq_len.sv
module crcq_len #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             take,
  input  logic             take_last,
  output logic [CNT_W-1:0] len_now_o,
  output logic [CNT_W-1:0] len_q_o
);
  logic [CNT_W-1:0] count;

  assign len_now_o = count + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count   <= '0;
      len_q_o <= '0;
    end else if (take) begin
      count <= take_last ? '0 : len_now_o;
      if (take_last) len_q_o <= len_now_o;
    end
  end
endmodule

// File: rtl/crcq_engine.sv
module crcq_engine
  import crcq_pkg::*;
#(
  parameter int ITERATIVE = 0,
  parameter int WORD_W    = 32,
  parameter int CNT_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORD_W-1:0]       in_data,
  input  logic                    in_last,
  output logic                    done,
  output logic [CRC_W-1:0]        crc_out,
  output logic [CNT_W+CRC_W-1:0]  hdr_out
);
  logic             busy;
  logic             take;
  logic             fin;
  crc_t             fin_crc;
  logic [CNT_W-1:0] len_now;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] len_sel;
  logic [CNT_W-1:0] hdr_cnt;

  assign in_ready = ~start & ~busy;
  assign take     = in_valid & in_ready;

  crcq_core #(.ITERATIVE(ITERATIVE), .WORD_W(WORD_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .clear     (start),
    .take      (take),
    .take_last (in_last),
    .word_i    (in_data),
    .busy_o    (busy),
    .fin_o     (fin),
    .fin_crc_o (fin_crc)
  );

  crcq_len #(.CNT_W(CNT_W)) u_len (
    .clk       (clk),
    .rst       (rst),
    .clear     (start),
    .take      (take),
    .take_last (in_last),
    .len_now_o (len_now),
    .len_q_o   (len_q)
  );

  // Unrolled finishes at the last take; iterative finishes later
  assign len_sel = (ITERATIVE != 0) ? len_q : len_now;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      done    <= 1'b0;
      crc_out <= '0;
      hdr_cnt <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        crc_out <= fin_crc;
        hdr_cnt <= len_sel;
      end
    end
  end

  assign hdr_out = {hdr_cnt, crc_out};
endmodule

// File: rtl/crcq_engine_chk.sv
module crcq_engine_chk #(
  parameter int ITERATIVE = 0,
  parameter int CNT_W     = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   in_last,
  input logic                   done,
  input logic [15:0]            crc_out,
  input logic [CNT_W+15:0]      hdr_out
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && crc_out == '0 && hdr_out == '0));

  a_r9_start_blocks_ready: assert property (@(posedge clk) disable iff (rst)
    start |-> !in_ready);

  a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
    $past(start) |-> (!done && crc_out == '0 && hdr_out == '0));

  a_r8_result_holds: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(start) && !$past(rst)) |-> ($stable(crc_out) && $stable(hdr_out)));

  a_r4_hdr_low_is_crc: assert property (@(posedge clk) disable iff (rst)
    done |-> (hdr_out[15:0] == crc_out));

  if (ITERATIVE != 0) begin : g_iter_chk
    a_r6_ready_drops: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
  end else begin : g_unroll_chk
    a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(in_valid && in_ready && in_last));
  end
endmodule

bind crcq_engine crcq_engine_chk #(.ITERATIVE(ITERATIVE), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_last  (in_last),
  .done     (done),
  .crc_out  (crc_out),
  .hdr_out  (hdr_out)
);

// File: tb/sim_crcq_engine.sv
`timescale 1ns/1ps
module sim_crcq_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st  = 1'b0;
  logic        v0  = 1'b0;
  logic        v1  = 1'b0;
  logic [31:0] din = '0;
  logic        dlast = 1'b0;
  logic        r0, r1, d0, d1;
  logic [15:0] c0, c1;
  logic [31:0] h0, h1;

  int checks = 0;
  int fails  = 0;
  logic [31:0] qbuf [0:63];

  always #5 clk = ~clk;

  crcq_engine #(.ITERATIVE(0)) u0 (
    .clk(clk), .rst(rst), .start(st), .in_valid(v0), .in_ready(r0),
    .in_data(din), .in_last(dlast), .done(d0), .crc_out(c0), .hdr_out(h0));

  crcq_engine #(.ITERATIVE(1)) u1 (
    .clk(clk), .rst(rst), .start(st), .in_valid(v1), .in_ready(r1),
    .in_data(din), .in_last(dlast), .done(d1), .crc_out(c1), .hdr_out(h1));

  // {length, seed}
  localparam logic [39:0] VEC [0:7] = '{
    {8'd1,  32'h0000_0001}, {8'd2,  32'h1234_5678}, {8'd3,  32'hCAFE_F00D},
    {8'd5,  32'h0BAD_BEEF}, {8'd8,  32'h5555_AAAA}, {8'd17, 32'h0F0F_1E1E},
    {8'd40, 32'h7777_1111}, {8'd64, 32'hFFFF_FFFF}};

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model(int n);
    logic [15:0] c;
    logic [3:0]  nb, t;
    c = 16'h0;
    for (int w = 0; w < n; w++) begin
      for (int k = 7; k >= 0; k--) begin
        nb = qbuf[w][4*k +: 4];
        t  = c[15:12] ^ nb;
        c  = {c[11:0], 4'h0} ^ {t, 12'h000} ^ {7'h00, t, 5'h00} ^ {12'h000, t};
      end
    end
    return c;
  endfunction

  task automatic fill(logic [31:0] seed, int n);
    logic [31:0] x;
    x = seed;
    for (int i = 0; i < n; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      qbuf[i] = x ^ {x[15:0], x[31:16]};
    end
  endtask

  function automatic logic rdy(int sel);
    return (sel == 0) ? r0 : r1;
  endfunction
  function automatic logic dn(int sel);
    return (sel == 0) ? d0 : d1;
  endfunction
  function automatic logic [15:0] crc(int sel);
    return (sel == 0) ? c0 : c1;
  endfunction
  function automatic logic [31:0] hdr(int sel);
    return (sel == 0) ? h0 : h1;
  endfunction

  task automatic set_v(int sel, logic val);
    if (sel == 0) v0 = val; else v1 = val;
  endtask

  task automatic pulse_start(int sel, bit bogus);
    @(negedge clk);
    st = 1'b1;
    if (bogus) begin
      din = 32'hDEAD_BEEF; dlast = 1'b1; set_v(sel, 1'b1);
      #1 chk(rdy(sel) == 1'b0, "R9", "ready during start", rdy(sel), 0);
    end
    @(negedge clk);
    st = 1'b0; set_v(sel, 1'b0); dlast = 1'b0;
    chk(crc(sel) == 16'h0 && hdr(sel) == 32'h0, "R8", "cleared by start", hdr(sel), 0);
  endtask

  // Feed qbuf[0..n-1]; optionally close the block and check the result
  task automatic feed(int sel, int n, int gaps, bit close, string req);
    int lat, low;
    logic [15:0] e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      din = qbuf[i]; dlast = close && (i == n - 1); set_v(sel, 1'b1);
      while (!rdy(sel)) @(negedge clk);
      if (gaps > 0 && i != n - 1) begin
        @(negedge clk);
        set_v(sel, 1'b0);
        repeat (gaps - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    set_v(sel, 1'b0); dlast = 1'b0;
    if (!close) return;
    lat = 0; low = 0;
    while (!dn(sel) && lat < 20) begin
      if (!rdy(sel)) low++;
      @(negedge clk);
      lat++;
    end
    e = model(n);
    chk(lat == ((sel == 0) ? 0 : 8), "R5", "done latency", lat, (sel == 0) ? 0 : 8);
    chk(low == ((sel == 0) ? 0 : 8), "R6", "ready low cycles", low, (sel == 0) ? 0 : 8);
    chk(crc(sel) == e, req, "crc value", crc(sel), e);
    chk(hdr(sel) == {n[15:0], e}, "R4", "header", hdr(sel), {n[15:0], e});
    @(negedge clk);
    chk(dn(sel) == 1'b0, "R5", "done single cycle", dn(sel), 0);
    chk(crc(sel) == e, "R8", "result held", crc(sel), e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog expired act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(d0 == 0 && d1 == 0, "R1", "done after reset", {d0, d1}, 0);
    chk(c0 == 0 && h0 == 0, "R1", "u0 result after reset", h0, 0);
    chk(c1 == 0 && h1 == 0, "R1", "u1 result after reset", h1, 0);
    chk(r0 == 1 && r1 == 1, "R1", "ready after reset", {r0, r1}, 2'b11);

    // Table walk on both variants: R2, R3
    for (int sel = 0; sel < 2; sel++) begin
      for (int k = 0; k < 8; k++) begin
        fill(VEC[k][31:0], int'(VEC[k][39:32]));
        pulse_start(sel, 1'b0);
        feed(sel, int'(VEC[k][39:32]), 0, 1'b1, "R2");
      end
    end

    // All-zero data keeps the check value at zero (R2)
    for (int i = 0; i < 3; i++) qbuf[i] = 32'h0;
    pulse_start(0, 1'b0);
    feed(0, 3, 0, 1'b1, "R2");
    chk(c0 == 16'h0, "R2", "zero data", c0, 0);

    for (int sel = 0; sel < 2; sel++) begin
      // R11 idle gaps between quadlets
      fill(32'h2468_ACE0, 6);
      pulse_start(sel, 1'b0);
      feed(sel, 6, 3, 1'b1, "R11");

      // R7 abort mid-block, then a fresh block
      fill(32'h1357_9BDF, 4);
      pulse_start(sel, 1'b0);
      feed(sel, 4, 0, 1'b0, "R7");
      fill(32'h0A0B_0C0D, 5);
      pulse_start(sel, 1'b0);
      feed(sel, 5, 0, 1'b1, "R7");

      // R9 quadlet offered with start is dropped; R3 exact coverage
      fill(32'h3C3C_5A5A, 4);
      pulse_start(sel, 1'b1);
      feed(sel, 4, 0, 1'b1, "R3");

      // R10 back-to-back blocks without start
      fill(32'h9999_0001, 7);
      feed(sel, 7, 0, 1'b1, "R10");
      fill(32'h4321_8765, 2);
      feed(sel, 2, 0, 1'b1, "R10");

      // R8 hold over idle cycles, then clear by start
      repeat (5) @(negedge clk);
      chk(crc(sel) == model(2), "R8", "held after idle", crc(sel), model(2));
      pulse_start(sel, 1'b0);
    end

    // R7 abort while the iterative variant is mid-quadlet
    fill(32'h7E57_0000, 1);
    @(negedge clk);
    din = qbuf[0]; dlast = 1'b1; v1 = 1'b1;
    @(negedge clk);
    v1 = 1'b0; dlast = 1'b0;
    repeat (3) @(negedge clk);
    st = 1'b1;
    @(negedge clk);
    st = 1'b0;
    repeat (10) @(negedge clk);
    chk(c1 == 16'h0 && h1 == 32'h0, "R7", "aborted quadlet gives no result", h1, 0);
    chk(r1 == 1'b1, "R7", "ready after abort", r1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule